// File: doc/BRIEF.md
# Exception Entry Arbiter

This block decides, at each instruction boundary, whether the core leaves its current flow for an exception handler. It watches two active-high hardware request lines, a fast one and a normal one, together with a software-trap strobe raised by the decoder. Each hardware line can be masked by its own disable bit in the current status word. The block ranks the live sources, fast first, then normal, then the software trap. For the winner it produces the handler address, the new status word and the data the register file must bank.

All results are registered. In the cycle after a qualifying boundary the block raises a one-cycle take pulse. In that same cycle it drives the handler address, the new status word, and write strobes with data for the link register and the saved status register of the entered mode. The new mode is carried in the low five bits of the status word, so the register file picks its bank from there. Handler code and the return path belong to other blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, take_exc, lr_we and spsr_we are 0, and vector_pc, status_out, lr_wdata and spsr_wdata are all zero.
- R2: A normal request taken at a boundary gives vector_pc = 0x18 one cycle later. status_out then has mode field [4:0] = 5'b10010, bit 7 set, bit 5 cleared, and bit 6 and bits [31:8] copied from status_in.
- R3: A fast request taken at a boundary gives vector_pc = 0x1C. status_out then has mode field 5'b10001, bits 7 and 6 set, bit 5 cleared, and bits [31:8] copied from status_in.
- R4: A software trap (swi_req high at a boundary with no hardware request winning) gives vector_pc = 0x08. status_out then has mode field 5'b10011, bit 7 set, bit 5 cleared, and bit 6 and bits [31:8] copied.
- R5: Priority is fast request, then normal request, then software trap. The losers in that boundary are not taken.
- R6: status_in bit 7 = 1 masks the normal request, and status_in bit 6 = 1 masks the fast request. The software trap has no mask.
- R7: With at_boundary low, no input causes take_exc, lr_we or spsr_we in the following cycle.
- R8: Whenever take_exc is high, lr_we and spsr_we are also high. lr_wdata equals pc_in + 4 and spsr_wdata equals status_in, both as sampled at the deciding boundary.
- R9: A request held high while masked is taken at the first boundary at which its disable bit reads 0.
- R10: take_exc is high only in a cycle that follows a boundary where a source won. Each boundary gives at most one one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Normal interrupt request, level |
| fiq_req | input | 1 | Fast interrupt request, level |
| swi_req | input | 1 | Software trap strobe from decode |
| at_boundary | input | 1 | Instruction boundary, enables sampling |
| status_in | input | XLEN | Current status word |
| pc_in | input | XLEN | Current program counter |
| take_exc | output | 1 | One-cycle exception entry pulse |
| vector_pc | output | XLEN | Handler address |
| status_out | output | XLEN | Status word after entry |
| lr_we | output | 1 | Write strobe for the new mode's link register |
| lr_wdata | output | XLEN | Return address written to the link register |
| spsr_we | output | 1 | Write strobe for the new mode's saved status register |
| spsr_wdata | output | XLEN | Old status word to save |

## Verification
The bound checker watches several rules on every cycle, whatever the stimulus. A pulse must always trace back to a boundary. Each saved value must match the previous cycle's inputs. A vector must never belong to a source whose disable bit was set. An unmasked fast request must always win, and entry into each mode must set the right bits. Only the bench's scenarios can show the full arbitration outcomes. These include a normal request beating a software trap, a masked normal request giving way to a trap, and a held request being taken only once its mask clears. The scenarios also show that the preserved upper status bits and the cleared state bit come out as expected for chosen status words.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

    localparam int MODE_W      = 5;
    localparam int IRQ_OFF_BIT = 7;
    localparam int FIQ_OFF_BIT = 6;
    localparam int STATE_BIT   = 5;
    localparam int LINK_STEP   = 4;
    localparam int NUM_SRC     = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011
    } cpu_mode_e;

    // Encoding order doubles as priority rank: higher value wins.
    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_SWI  = 2'd1,
        EXC_IRQ  = 2'd2,
        EXC_FIQ  = 2'd3
    } exc_kind_e;

    typedef struct packed {
        logic      taken;
        exc_kind_e kind;
    } exc_decision_t;

    function automatic logic [7:0] vector_offset(exc_kind_e k);
        case (k)
            EXC_FIQ: return 8'h1C;
            EXC_IRQ: return 8'h18;
            EXC_SWI: return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cpu_mode_e entry_mode(exc_kind_e k);
        case (k)
            EXC_FIQ: return MODE_FIQ;
            EXC_IRQ: return MODE_IRQ;
            default: return MODE_SVC;
        endcase
    endfunction

    function automatic logic blocks_fast(exc_kind_e k);
        return k == EXC_FIQ;
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
`timescale 1ns/1ps
module exc_prio_arb
    import exc_entry_pkg::*;
(
    input  logic          irq_req,
    input  logic          fiq_req,
    input  logic          swi_req,
    input  logic          at_boundary,
    input  logic          irq_off,
    input  logic          fiq_off,
    output exc_decision_t dec_o
);

    logic [NUM_SRC-1:0] live;

    // Index i maps to exc_kind_e value i+1.
    assign live[0] = at_boundary & swi_req;
    assign live[1] = at_boundary & irq_req & ~irq_off;
    assign live[2] = at_boundary & fiq_req & ~fiq_off;

    always_comb begin
        dec_o.taken = 1'b0;
        dec_o.kind  = EXC_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (live[i]) begin
                dec_o.taken = 1'b1;
                dec_o.kind  = exc_kind_e'(2'(i + 1));
            end
        end
    end

endmodule

// File: rtl/exc_status_build.sv
`timescale 1ns/1ps
module exc_status_build
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status_i,
    input  exc_kind_e       kind_i,
    output logic [XLEN-1:0] status_o
);

    cpu_mode_e new_mode;

    always_comb begin
        new_mode              = entry_mode(kind_i);
        status_o              = status_i;
        status_o[MODE_W-1:0]  = new_mode;
        status_o[STATE_BIT]   = 1'b0;
        status_o[IRQ_OFF_BIT] = 1'b1;
        if (blocks_fast(kind_i)) begin
            status_o[FIQ_OFF_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/exc_link_calc.sv
`timescale 1ns/1ps
module exc_link_calc
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic [XLEN-1:0] pc_i,
    input  exc_kind_e       kind_i,
    output logic [XLEN-1:0] link_o,
    output logic [XLEN-1:0] vector_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(LINK_STEP);

    assign link_o   = pc_i + STEP;
    assign vector_o = VEC_BASE + XLEN'(vector_offset(kind_i));

endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_req,
    input  logic            fiq_req,
    input  logic            swi_req,
    input  logic            at_boundary,
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] pc_in,
    output logic            take_exc,
    output logic [XLEN-1:0] vector_pc,
    output logic [XLEN-1:0] status_out,
    output logic            lr_we,
    output logic [XLEN-1:0] lr_wdata,
    output logic            spsr_we,
    output logic [XLEN-1:0] spsr_wdata
);

    exc_decision_t   dec;
    logic [XLEN-1:0] st_next;
    logic [XLEN-1:0] link_next;
    logic [XLEN-1:0] vec_next;

    exc_prio_arb u_arb (
        .irq_req     (irq_req),
        .fiq_req     (fiq_req),
        .swi_req     (swi_req),
        .at_boundary (at_boundary),
        .irq_off     (status_in[IRQ_OFF_BIT]),
        .fiq_off     (status_in[FIQ_OFF_BIT]),
        .dec_o       (dec)
    );

    exc_status_build #(.XLEN(XLEN)) u_stat (
        .status_i (status_in),
        .kind_i   (dec.kind),
        .status_o (st_next)
    );

    exc_link_calc #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_link (
        .pc_i     (pc_in),
        .kind_i   (dec.kind),
        .link_o   (link_next),
        .vector_o (vec_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_exc   <= 1'b0;
            lr_we      <= 1'b0;
            spsr_we    <= 1'b0;
            vector_pc  <= '0;
            status_out <= '0;
            lr_wdata   <= '0;
            spsr_wdata <= '0;
        end else begin
            take_exc <= dec.taken;
            lr_we    <= dec.taken;
            spsr_we  <= dec.taken;
            if (dec.taken) begin
                vector_pc  <= vec_next;
                status_out <= st_next;
                lr_wdata   <= link_next;
                spsr_wdata <= status_in;
            end
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_req,
    input logic            fiq_req,
    input logic            swi_req,
    input logic            at_boundary,
    input logic [XLEN-1:0] status_in,
    input logic [XLEN-1:0] pc_in,
    input logic            take_exc,
    input logic [XLEN-1:0] vector_pc,
    input logic [XLEN-1:0] status_out,
    input logic            lr_we,
    input logic [XLEN-1:0] lr_wdata,
    input logic            spsr_we,
    input logic [XLEN-1:0] spsr_wdata
);

    localparam logic [XLEN-1:0] V_FIQ = VEC_BASE + XLEN'(8'h1C);
    localparam logic [XLEN-1:0] V_IRQ = VEC_BASE + XLEN'(8'h18);
    localparam logic [XLEN-1:0] V_SWI = VEC_BASE + XLEN'(8'h08);

    p_quiet_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !take_exc && !lr_we && !spsr_we);

    p_boundary_only_r7: assert property (@(posedge clk) disable iff (rst)
        take_exc |-> $past(at_boundary));

    p_saves_r8: assert property (@(posedge clk) disable iff (rst)
        take_exc |-> lr_we && spsr_we && lr_wdata == $past(pc_in) + XLEN'(LINK_STEP)
                     && spsr_wdata == $past(status_in));

    p_irq_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (take_exc && vector_pc == V_IRQ) |-> !$past(status_in[IRQ_OFF_BIT]) && $past(irq_req));

    p_fiq_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (take_exc && vector_pc == V_FIQ) |-> !$past(status_in[FIQ_OFF_BIT]) && $past(fiq_req));

    p_fiq_wins_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && at_boundary && fiq_req && !status_in[FIQ_OFF_BIT])
        |-> take_exc && vector_pc == V_FIQ);

    p_fiq_status_r3: assert property (@(posedge clk) disable iff (rst)
        (take_exc && vector_pc == V_FIQ) |->
        status_out[MODE_W-1:0] == MODE_FIQ && status_out[IRQ_OFF_BIT] && status_out[FIQ_OFF_BIT]);

    p_irq_status_r2: assert property (@(posedge clk) disable iff (rst)
        (take_exc && vector_pc == V_IRQ) |->
        status_out[MODE_W-1:0] == MODE_IRQ && status_out[IRQ_OFF_BIT] && !status_out[STATE_BIT]);

    p_swi_status_r4: assert property (@(posedge clk) disable iff (rst)
        (take_exc && vector_pc == V_SWI) |->
        status_out[MODE_W-1:0] == MODE_SVC && $past(swi_req)
        && status_out[FIQ_OFF_BIT] == $past(status_in[FIQ_OFF_BIT]));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_req     (irq_req),
    .fiq_req     (fiq_req),
    .swi_req     (swi_req),
    .at_boundary (at_boundary),
    .status_in   (status_in),
    .pc_in       (pc_in),
    .take_exc    (take_exc),
    .vector_pc   (vector_pc),
    .status_out  (status_out),
    .lr_we       (lr_we),
    .lr_wdata    (lr_wdata),
    .spsr_we     (spsr_we),
    .spsr_wdata  (spsr_wdata)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0, fiq_req = 1'b0, swi_req = 1'b0, at_boundary = 1'b0;
    logic [31:0] status_in = '0, pc_in = '0;
    logic        take_exc, lr_we, spsr_we;
    logic [31:0] vector_pc, status_out, lr_wdata, spsr_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        take;
        logic [31:0] vec;
        logic [31:0] st;
        logic [31:0] lr;
        logic [31:0] sp;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req), .fiq_req(fiq_req), .swi_req(swi_req),
        .at_boundary(at_boundary), .status_in(status_in), .pc_in(pc_in),
        .take_exc(take_exc), .vector_pc(vector_pc), .status_out(status_out),
        .lr_we(lr_we), .lr_wdata(lr_wdata), .spsr_we(spsr_we), .spsr_wdata(spsr_wdata)
    );

    // Expected outcome built from the requirement text.
    function automatic exp_t model(logic i, logic f, logic s, logic b,
                                   logic [31:0] st, logic [31:0] pc);
        exp_t e = '0;
        logic [4:0] md;
        logic       set6;
        if (!b) return e;
        if (f && !st[6]) begin
            e.vec = 32'h1C; md = 5'b10001; set6 = 1'b1;
        end else if (i && !st[7]) begin
            e.vec = 32'h18; md = 5'b10010; set6 = st[6];
        end else if (s) begin
            e.vec = 32'h08; md = 5'b10011; set6 = st[6];
        end else begin
            return e;
        end
        e.take = 1'b1;
        e.st   = {st[31:8], 1'b1, set6, 1'b0, md};
        e.lr   = pc + 32'd4;
        e.sp   = st;
        return e;
    endfunction

    task automatic drive(input logic i, input logic f, input logic s, input logic b,
                         input logic [31:0] st, input logic [31:0] pc, input string tag);
        @(negedge clk);
        irq_req = i; fiq_req = f; swi_req = s; at_boundary = b;
        status_in = st; pc_in = pc;
        exp_q.push_back(model(i, f, s, b, st, pc));
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (take_exc !== e.take || lr_we !== e.take || spsr_we !== e.take) begin
                errors++;
                $display("FAIL %s: take/lr_we/spsr_we=%b%b%b expected %b", t,
                         take_exc, lr_we, spsr_we, e.take);
            end else if (e.take && (vector_pc !== e.vec || status_out !== e.st ||
                                    lr_wdata !== e.lr || spsr_wdata !== e.sp)) begin
                errors++;
                $display("FAIL %s: vec=%h st=%h lr=%h sp=%h expected vec=%h st=%h lr=%h sp=%h",
                         t, vector_pc, status_out, lr_wdata, spsr_wdata,
                         e.vec, e.st, e.lr, e.sp);
            end
        end
    end

    task automatic check_reset(input string t);
        checks++;
        if (take_exc !== 1'b0 || lr_we !== 1'b0 || spsr_we !== 1'b0 || vector_pc !== '0 ||
            status_out !== '0 || lr_wdata !== '0 || spsr_wdata !== '0) begin
            errors++;
            $display("FAIL %s: take=%b vec=%h st=%h lr=%h sp=%h expected all zero",
                     t, take_exc, vector_pc, status_out, lr_wdata, spsr_wdata);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check_reset("R1 during reset");
        @(negedge clk) rst = 1'b0;
        @(posedge clk) #1 check_reset("R1 after reset");

        drive(1, 0, 0, 1, 32'hF000_0010, 32'h0000_1000, "R2 irq entry");
        drive(0, 1, 0, 1, 32'h0000_0010, 32'h0000_2000, "R3 fiq entry");
        drive(0, 0, 1, 1, 32'h6000_0070, 32'h0000_3000, "R4 swi entry");
        drive(1, 1, 1, 1, 32'h2000_0010, 32'h0000_4000, "R5 fiq beats irq and swi");
        drive(1, 0, 1, 1, 32'h0000_0050, 32'h0000_5000, "R5 irq beats swi");
        drive(1, 0, 0, 1, 32'h0000_0090, 32'h0000_6000, "R6 irq masked");
        drive(1, 0, 1, 1, 32'h0000_0090, 32'h0000_6004, "R6 swi unmaskable");
        drive(1, 1, 0, 1, 32'h0000_0050, 32'h0000_7000, "R6 fiq masked irq wins");
        drive(0, 1, 0, 1, 32'h0000_0092, 32'h0000_7100, "R3 fiq from irq mode");
        drive(1, 1, 1, 0, 32'h0000_0010, 32'h0000_8000, "R7 no boundary");
        drive(0, 0, 0, 0, 32'h0000_0010, 32'h0000_8004, "R10 idle");
        drive(1, 0, 0, 1, 32'h0000_00D0, 32'h0000_9000, "R9 held masked 1");
        drive(1, 0, 0, 0, 32'h0000_0010, 32'h0000_9004, "R9 unmasked off boundary");
        drive(1, 0, 0, 1, 32'h0000_0010, 32'h0000_9008, "R9 taken when unmasked");
        drive(0, 0, 0, 0, 32'h0000_0010, 32'h0000_900C, "R10 single pulse");
        drive(0, 0, 0, 1, 32'hFFFF_FF00, 32'hFFFF_FFFC, "R10 boundary no source");
        drive(0, 0, 1, 1, 32'hFFFF_FF1F, 32'hFFFF_FFFC, "R8 link wraps");
        drive(0, 0, 0, 0, 32'h0, 32'h0, "R10 final idle");
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule